// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block turns parallel words written by software into asynchronous serial frames on one output line. A single holding register sits in front of the frame shifter, so software can queue the next word while the current frame is still on the wire. Each of the two stages has its own empty flag. An interrupt request can be raised either when the holding register hands its word to the shifter or when the line falls idle.

The frame format is chosen at the moment a word enters the shifter. It covers the data length (7, 8 or 9 bits), optional even or odd parity over the data bits, and one or two stop bits. The bit time comes from a divider that counts pulses of a clock-enable input, so the whole block runs in one clock domain. A clear-to-send input, when enabled, is synchronized and consulted only at frame boundaries: it can hold back the next frame but never cuts a frame short. Dropping the transmit enable has the same effect.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset `txd` is 1, `buf_empty` is 1, `sr_empty` is 1 and `irq` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bits at 1. `txd` is 1 whenever no frame is running.
- R3: Every bit of a frame lasts exactly 16 × (`divisor` + 1) cycles in which `clk_en` is 1.
- R4: A cycle with `wr_stb` high makes `buf_empty` 0 on the next cycle. The hand-over of the held word to the shifter makes `buf_empty` 1 on the next cycle, unless a write arrives in the same cycle.
- R5: `sr_empty` falls on the cycle after a hand-over. It rises on the cycle after the last stop bit ends, if no hand-over happens at that edge. If one does, the next start bit follows with no idle cycle.
- R6: `data_len` 2'b00 selects 7 data bits, 2'b10 selects 9, and 2'b01 or 2'b11 select 8. With `par_en` set, the parity bit makes the count of ones over the data bits and the parity bit even when `par_odd` is 0 and odd when it is 1. `two_stop` selects two stop bits.
- R7: With `irq_sel` 0, a hand-over sets `irq`. With `irq_sel` 1, a frame end without a following hand-over sets `irq`. `irq` stays set until a cycle with `irq_clear` high, and a set event in that same cycle wins.
- R8: With `cts_en` 1, no frame starts while `cts_in`, delayed by two clock flops, is 1. A running frame always completes. A frame waits until the delayed `cts_in` is 0.
- R9: While `tx_en` is 0, no frame starts and the running frame completes.
- R10: A write while the holding register is full replaces the held word, and only the newest word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count enable for the bit-time divider |
| divisor | input | DIV_W | Divider value n; bit time is 16(n+1) enabled cycles |
| tx_en | input | 1 | Allows new frames to start |
| data_len | input | 2 | Data length code |
| par_en | input | 1 | Appends a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | 1 selects two stop bits |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_in | input | 1 | Clear-to-send input, high means hold off |
| irq_sel | input | 1 | Interrupt cause: 0 hand-over, 1 line idle |
| irq_clear | input | 1 | Acknowledge / software clear of `irq` |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to transmit |
| txd | output | 1 | Serial output |
| buf_empty | output | 1 | Holding register is empty |
| sr_empty | output | 1 | No frame is being shifted |
| irq | output | 1 | Interrupt request |

## Verification
A write reaches `buf_empty` one edge later. The hand-over follows on the next edge, so a word written to an idle transmitter drives the start bit two edges after its strobe. `txd` then changes exactly 16(n+1) enabled cycles after each bit boundary. `sr_empty` and the line-idle interrupt rise on the edge that ends the last stop bit. A clear-to-send release takes three edges to start a frame, because of the two synchronizer flops. The bench's behavioural model applies these same latencies, one edge at a time, to the inputs it sees at each rising edge, and it compares every output at the following falling edge. The directed checks count falling edges from the stimulus to exactly these points.

// File: rtl/utx_pkg.sv
package utx_pkg;
   localparam int MAX_DATA = 9;
   localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
   localparam int IDX_W    = $clog2(FRAME_W);

   typedef enum logic [1:0] {
      LEN_7  = 2'b00,
      LEN_8  = 2'b01,
      LEN_9  = 2'b10,
      LEN_8R = 2'b11
   } dlen_e;

   typedef struct packed {
      logic [1:0] dlen;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
   } fmt_t;

   function automatic int data_bits(logic [1:0] code);
      case (dlen_e'(code))
         LEN_7:   return 7;
         LEN_9:   return 9;
         default: return 8;
      endcase
   endfunction
endpackage

// File: rtl/utx_sync.sv
module utx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("utx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/utx_baud.sv
module utx_baud #(
   parameter int DIV_W = 8,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             bit_end
);
   localparam int OVS_LG = $clog2(OVS);
   localparam int CNT_W  = DIV_W + OVS_LG;

   generate
      if (OVS < 2 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("utx_baud: OVS must be a power of two, at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("utx_baud: DIV_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             at_lim;

   assign limit  = {divisor, {OVS_LG{1'b1}}};
   assign at_lim = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || !run)   cnt_q <= '0;
      else if (clk_en)            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
   end

   assign bit_end = run & clk_en & at_lim;

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clk_en && !at_lim && !restart) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   // R3
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || restart) |=> (cnt_q == '0));
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import utx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [MAX_DATA-1:0] data,
   input  fmt_t                fmt,
   input  logic                bit_end,
   output logic                busy,
   output logic                frame_done,
   output logic                txd
);
   logic [FRAME_W-1:0] sr_q;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   last_q;
   logic               busy_q;

   function automatic logic [FRAME_W-1:0] build_frame(logic [MAX_DATA-1:0] d, fmt_t f);
      logic [FRAME_W-1:0] fr;
      logic               p;
      int                 n;
      n     = data_bits(f.dlen);
      fr    = '1;
      fr[0] = 1'b0;
      p     = f.par_odd;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (i < n) begin
            fr[1+i] = d[i];
            p       = p ^ d[i];
         end
      end
      if (f.par_en) fr[1+n] = p;
      return fr;
   endfunction

   function automatic logic [IDX_W-1:0] last_index(fmt_t f);
      int n;
      n = data_bits(f.dlen) + (f.par_en ? 1 : 0) + (f.two_stop ? 2 : 1);
      return IDX_W'(n);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '1;
         idx_q  <= '0;
         last_q <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         sr_q   <= build_frame(data, fmt);
         idx_q  <= '0;
         last_q <= last_index(fmt);
         busy_q <= 1'b1;
      end else if (bit_end) begin
         if (idx_q == last_q) begin
            busy_q <= 1'b0;
         end else begin
            sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign busy       = busy_q;
   assign frame_done = busy_q & bit_end & (idx_q == last_q);
   assign txd        = busy_q ? sr_q[0] : 1'b1;

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !txd);
   // R2
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !bit_end && !load) |=> $stable(txd));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
   import utx_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clk_en,
   input  logic [DIV_W-1:0]    divisor,
   input  logic                tx_en,
   input  logic [1:0]          data_len,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                two_stop,
   input  logic                cts_en,
   input  logic                cts_in,
   input  logic                irq_sel,
   input  logic                irq_clear,
   input  logic                wr_stb,
   input  logic [MAX_DATA-1:0] wr_data,
   output logic                txd,
   output logic                buf_empty,
   output logic                sr_empty,
   output logic                irq
);
   logic [MAX_DATA-1:0] hold_q;
   logic                hold_full_q;
   logic                irq_q;
   logic                cts_s;
   logic                busy;
   logic                frame_done;
   logic                bit_end;
   logic                load;
   logic                irq_set;
   fmt_t                fmt;

   assign fmt = '{dlen: data_len, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

   utx_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_in),
      .q     (cts_s)
   );

   assign load = tx_en & hold_full_q & ~(cts_en & cts_s) & (~busy | frame_done);

   utx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .run     (busy),
      .restart (load),
      .divisor (divisor),
      .bit_end (bit_end)
   );

   utx_shifter u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .data       (hold_q),
      .fmt        (fmt),
      .bit_end    (bit_end),
      .busy       (busy),
      .frame_done (frame_done),
      .txd        (txd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (wr_stb) begin
         hold_q      <= wr_data;
         hold_full_q <= 1'b1;
      end else if (load) begin
         hold_full_q <= 1'b0;
      end
   end

   assign irq_set = irq_sel ? (frame_done & ~load) : load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_set | (irq_q & ~irq_clear);
   end

   assign buf_empty = ~hold_full_q;
   assign sr_empty  = ~busy;
   assign irq       = irq_q;

   // R4
   wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !buf_empty);
   // R4
   handover_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_stb) |=> buf_empty);
   // R5
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !load) |=> sr_empty);
   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clear) |=> irq);
   // R7
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sel && frame_done && !load) |=> irq);
   // R8
   cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_empty) |-> !$past(cts_en && cts_s));
   // R9
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_empty) |-> $past(tx_en));
endmodule

// File: tb/uart_tx_dbuf_tb_top.sv
module uart_tx_dbuf_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic [7:0] divisor = 8'd1;
   logic       tx_en = 1'b1;
   logic [1:0] data_len = 2'b01;
   logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic       cts_en = 1'b0, cts_in = 1'b0;
   logic       irq_sel = 1'b0, irq_clear = 1'b0;
   logic       wr_stb = 1'b0;
   logic [8:0] wr_data = '0;
   logic       txd, buf_empty, sr_empty, irq;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int en_ph = 0;
   bit slow_en = 0;

   always #10 clk = ~clk;

   uart_tx_dbuf dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .divisor(divisor),
      .tx_en(tx_en), .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
      .two_stop(two_stop), .cts_en(cts_en), .cts_in(cts_in), .irq_sel(irq_sel),
      .irq_clear(irq_clear), .wr_stb(wr_stb), .wr_data(wr_data),
      .txd(txd), .buf_empty(buf_empty), .sr_empty(sr_empty), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // behavioural reference model
   bit         mq[$];
   logic [8:0] mbuf[$];
   int         mcnt = 0;
   bit         mrun = 0, mirq = 0, mc1 = 0, mc2 = 0;

   task automatic make_frame(logic [8:0] d);
      int  nb;
      bit  p;
      nb = (data_len == 2'b00) ? 7 : (data_len == 2'b10) ? 9 : 8;
      mq.delete();
      mq.push_back(1'b0);
      p = par_odd;
      for (int i = 0; i < nb; i++) begin
         mq.push_back(d[i]);
         p = p ^ d[i];
      end
      if (par_en) mq.push_back(p);
      mq.push_back(1'b1);
      if (two_stop) mq.push_back(1'b1);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); mbuf.delete();
         mcnt = 0; mrun = 0; mirq = 0; mc1 = 0; mc2 = 0;
      end else begin
         bit ok, endnow, ld, evt;
         int lim;
         lim    = 16 * (int'(divisor) + 1) - 1;
         ok     = tx_en && (mbuf.size() > 0) && !(cts_en && mc2);
         endnow = mrun && clk_en && (mcnt == lim) && (mq.size() == 1);
         ld     = ok && (!mrun || endnow);
         evt    = 0;
         if (mrun && clk_en) begin
            if (mcnt == lim) begin
               mcnt = 0;
               void'(mq.pop_front());
               if (mq.size() == 0) mrun = 0;
            end else mcnt++;
         end
         if (ld) begin
            make_frame(mbuf.pop_front());
            mrun = 1; mcnt = 0;
            if (!irq_sel) evt = 1;
         end else if (endnow && irq_sel) evt = 1;
         if (wr_stb) begin
            mbuf.delete();
            mbuf.push_back(wr_data);
         end
         mirq = evt || (mirq && !irq_clear);
         mc2 = mc1; mc1 = cts_in;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2,R6 txd vs model", txd, mrun ? mq[0] : 1'b1);
         chk("R4,R10 buf_empty vs model", buf_empty, mbuf.size() == 0);
         chk("R5 sr_empty vs model", sr_empty, !mrun);
         chk("R7 irq vs model", irq, mirq);
      end
      en_ph = (en_ph + 1) % 3;
      clk_en = slow_en ? (en_ph == 0) : 1'b1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL R5 watchdog actual=hung expected=idle");
         finish_run();
      end
   end

   task automatic send(logic [8:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(sr_empty && buf_empty));
   endtask

   task automatic pulse_clear();
      @(negedge clk); irq_clear = 1'b1;
      @(negedge clk); irq_clear = 1'b0;
   endtask

   initial begin
      int low;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 txd", txd, 1); chk("R1 buf_empty", buf_empty, 1);
      chk("R1 sr_empty", sr_empty, 1); chk("R1 irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 start bit length, 8N1, divisor 1
      send(9'h0A5);
      while (txd) @(negedge clk);
      low = 0;
      while (!txd) begin low++; @(negedge clk); end
      chk("R3 start bit cycles", low, 32);
      wait_idle();
      chk("R7 irq after hand-over (sel0)", irq, 1);
      pulse_clear();
      chk("R7 irq cleared", irq, 0);

      // R5 back-to-back frames
      send(9'h03C);
      while (!buf_empty) @(negedge clk);
      send(9'h081);
      wait_idle();

      // R6 formats
      data_len = 2'b00; par_en = 1; par_odd = 0;
      send(9'h05B); wait_idle();
      data_len = 2'b10; par_odd = 1; two_stop = 1;
      send(9'h1C3); wait_idle();
      par_en = 0;
      send(9'h155); wait_idle();
      data_len = 2'b11; two_stop = 0;
      send(9'h0F0); wait_idle();

      // R7 line-idle interrupt
      data_len = 2'b01; irq_sel = 1;
      pulse_clear();
      send(9'h066);
      repeat (3) @(negedge clk);
      chk("R7 no irq mid-frame (sel1)", irq, 0);
      wait_idle();
      @(negedge clk);
      chk("R7 irq at idle (sel1)", irq, 1);
      pulse_clear();

      // R3 slow enable, divisor 0
      slow_en = 1; divisor = 8'd0;
      send(9'h0C9); wait_idle();
      slow_en = 0; divisor = 8'd1;

      // R9, R10 transmit disabled, overwrite
      tx_en = 0;
      send(9'h011); send(9'h022);
      repeat (100) @(negedge clk);
      chk("R9 no start while disabled", sr_empty, 1);
      chk("R9 line high while disabled", txd, 1);
      chk("R10 word held", buf_empty, 0);
      tx_en = 1;
      wait_idle();

      // R9 disable mid-frame: frame completes
      send(9'h0AA);
      repeat (20) @(negedge clk);
      tx_en = 0;
      send(9'h033);
      while (!sr_empty) @(negedge clk);
      chk("R9 next word waits", buf_empty, 0);
      tx_en = 1;
      wait_idle();

      // R8 clear-to-send gating
      cts_en = 1; cts_in = 1;
      repeat (3) @(negedge clk);
      send(9'h04E);
      repeat (100) @(negedge clk);
      chk("R8 held by cts", sr_empty, 1);
      cts_in = 0;
      repeat (4) @(negedge clk);
      chk("R8 starts after cts low", sr_empty, 0);
      while (!buf_empty) @(negedge clk);
      send(9'h0B7);
      repeat (50) @(negedge clk);
      cts_in = 1;
      chk("R8 running frame continues", sr_empty, 0);
      while (!sr_empty) @(negedge clk);
      repeat (40) @(negedge clk);
      chk("R8 second frame paused", buf_empty, 0);
      cts_in = 0;
      wait_idle();
      cts_en = 0;
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule